// File: doc/BRIEF.md
# Parallel Port Nibble-Mode Byte Receiver

This block is the host end of a reverse-channel link on a parallel printer port. The port has already been negotiated into nibble mode. The peripheral sends each byte as two 4-bit halves on four of its status lines. Each half is framed by a request/acknowledge handshake: the host drives the auto-feed control line, and the peripheral answers on its acknowledge line. The receiver rebuilds each byte from the two halves and hands it out on a valid/ready output.

A burst starts with a single request that carries a byte count. The engine fetches bytes one at a time. It asks for the next byte only after the previous one has been taken. When the burst is complete it raises a one-cycle done pulse.

Every wait on the peripheral is bounded by a timeout counted in ticks, and a tick is a fixed number of clock cycles. The wait for the first half of a byte may be long, because the peripheral may have nothing to send yet. Every later step has a short limit. When any step expires, the burst stops, a sticky error is raised, and the count of bytes already delivered is kept for inspection. The status and acknowledge inputs pass through a synchronizer before they are used.

Top module: `nibrx_top`

## Requirements
- R1: After reset and whenever no burst is running, `nautofd_o` is 1 and `busy_o`, `byte_valid_o`, `done_o` and `err_o` are 0. `nstrobe_o` and `nselectin_o` are always 1, and `ninit_o` is always 0.
- R2: A `req_valid_i` pulse while idle starts a burst. It clears `delivered_o` and `err_o`, raises `busy_o` and drives `nautofd_o` to 0 to request the first nibble. A `req_valid_i` pulse during a burst is ignored, and the burst keeps its original count.
- R3: While a nibble is requested, a synchronized low on `nack_n_i` makes the block drive `nautofd_o` back to 1. For the first nibble of a byte, it latches the status lines into the byte's low half: `nfault_i` into bit 0, `select_i` into bit 1, `perror_i` into bit 2 and `pbusy_i` into bit 3.
- R4: For the second nibble, the same four lines are latched into bits 4 to 7, in the same line order as R3.
- R5: After each nibble the block waits for `nack_n_i` to return high before it drives `nautofd_o` low again for the next nibble.
- R6: A completed byte appears on `byte_data_o` with `byte_valid_o` set. Both hold unchanged until `byte_ready_i` is seen. While the byte is waiting, `nautofd_o` stays 1, so no new nibble is requested.
- R7: When the last requested byte is accepted, `done_o` pulses for exactly one cycle, `busy_o` falls in the same cycle, and `delivered_o` equals the requested count.
- R8: If `nack_n_i` does not go low within `FIRST_LIMIT` ticks of the first-nibble request, the burst ends with `err_o` set and `busy_o` cleared. `delivered_o` keeps the number of bytes already accepted. A response that comes later than `STEP_LIMIT` ticks but inside `FIRST_LIMIT` ticks is accepted.
- R9: The second-nibble wait, and each wait for `nack_n_i` to return high, ends the burst with `err_o` set after `STEP_LIMIT` ticks.
- R10: A request with a count of zero completes at once with a `done_o` pulse, and no handshake takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a burst (sampled while idle) |
| req_count_i | input | CNT_W | Number of bytes to receive |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at burst completion |
| err_o | output | 1 | Burst ended by a timeout (held until the next start) |
| delivered_o | output | CNT_W | Bytes accepted in the current or last burst |
| nack_n_i | input | 1 | Peripheral acknowledge line (active low) |
| nfault_i | input | 1 | Status line carrying nibble bit 0 |
| select_i | input | 1 | Status line carrying nibble bit 1 |
| perror_i | input | 1 | Status line carrying nibble bit 2 |
| pbusy_i | input | 1 | Status line carrying nibble bit 3 |
| nautofd_o | output | 1 | Nibble request line (low = request) |
| nstrobe_o | output | 1 | Strobe line, held high |
| nselectin_o | output | 1 | Select-in line, held high |
| ninit_o | output | 1 | Init line, held low |
| byte_valid_o | output | 1 | Received byte available |
| byte_data_o | output | 8 | Received byte |
| byte_ready_i | input | 1 | Consumer takes the byte |

## Verification
The properties assume that the consumer raises `byte_ready_i` only on its own schedule, and that `req_valid_i` can arrive at any time. The bench pulses `req_valid_i` once in the middle of a burst on purpose.

The properties also assume that the status lines are settled before `nack_n_i` falls and stay settled until the falling edge has passed through the synchronizer. The peripheral model in the bench therefore drives the nibble one cycle ahead of the acknowledge, and scrambles the lines only after the acknowledge has returned high.

Response delays in the stimulus are kept well inside the step limit. The exceptions are the cases built to test the timeouts, which either wait for a set time inside the long window or never answer at all.

// File: rtl/nibrx_pkg.sv
package nibrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACKH = 2'd2,
    ST_HOLD = 2'd3
  } nibrx_state_e;

  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/nibrx_sync.sv
module nibrx_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nibrx_tick.sv
module nibrx_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      logic [DW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == DW'(DIV - 1));

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + DW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = wrap;
    end
  endgenerate
endmodule

// File: rtl/nibrx_timer.sv
module nibrx_timer #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired_o = (cnt_q >= limit_i);
  assign cnt_en    = clr_i | (tick_i & ~expired_o);

  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nibrx_top.sv
module nibrx_top
  import nibrx_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TICK_DIV    = 50,
  parameter int unsigned FIRST_LIMIT = 2000,
  parameter int unsigned STEP_LIMIT  = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [CNT_W-1:0]  req_count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  delivered_o,
  input  logic              nack_n_i,
  input  logic              nfault_i,
  input  logic              select_i,
  input  logic              perror_i,
  input  logic              pbusy_i,
  output logic              nautofd_o,
  output logic              nstrobe_o,
  output logic              nselectin_o,
  output logic              ninit_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  input  logic              byte_ready_i
);
  localparam int unsigned MAX_LIM = (FIRST_LIMIT > STEP_LIMIT) ? FIRST_LIMIT : STEP_LIMIT;
  localparam int unsigned TMR_W   = $clog2(MAX_LIM + 1);
  localparam int unsigned PIN_W   = NIB_W + 1;

  // Synchronized peripheral lines: {nack, nibble[3:0]}
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             nack_s;
  logic [NIB_W-1:0] nib_s;

  assign pins_raw = {nack_n_i, pbusy_i, perror_i, select_i, nfault_i};

  nibrx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL({PIN_W{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign nack_s = pins_s[PIN_W-1];
  assign nib_s  = pins_s[NIB_W-1:0];

  logic tick;
  nibrx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  // State
  nibrx_state_e      state_q, state_d;
  logic              hi_q, hi_d;
  logic [7:0]        data_q, data_d;
  logic              data_en;
  logic [CNT_W-1:0]  target_q, target_d;
  logic [CNT_W-1:0]  deliv_q, deliv_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  deliv_inc;

  logic              tmr_clr, tmr_exp;
  logic [TMR_W-1:0]  tmr_limit;

  assign deliv_inc = deliv_q + CNT_W'(1);
  assign tmr_limit = (state_q == ST_REQ && !hi_q) ? TMR_W'(FIRST_LIMIT) : TMR_W'(STEP_LIMIT);
  assign tmr_clr   = (state_q != state_d) || (state_q == ST_IDLE) || (state_q == ST_HOLD);

  nibrx_timer #(.W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .tick_i    (tick),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    hi_d     = hi_q;
    data_d   = data_q;
    data_en  = 1'b0;
    target_d = target_q;
    deliv_d  = deliv_q;
    err_d    = err_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          target_d = req_count_i;
          deliv_d  = '0;
          err_d    = 1'b0;
          hi_d     = 1'b0;
          if (req_count_i == '0) done_d  = 1'b1;
          else                   state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!nack_s) begin
          data_en = 1'b1;
          if (hi_q) data_d = {nib_s, data_q[NIB_W-1:0]};
          else      data_d = {data_q[BYTE_W-1:NIB_W], nib_s};
          state_d = ST_ACKH;
        end else if (tmr_exp) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_ACKH: begin
        if (nack_s) begin
          if (hi_q) begin
            state_d = ST_HOLD;
          end else begin
            hi_d    = 1'b1;
            state_d = ST_REQ;
          end
        end else if (tmr_exp) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (byte_ready_i) begin
          deliv_d = deliv_inc;
          hi_d    = 1'b0;
          if (deliv_inc == target_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      hi_q     <= 1'b0;
      target_q <= '0;
      deliv_q  <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      hi_q     <= hi_d;
      target_q <= target_d;
      deliv_q  <= deliv_d;
      err_q    <= err_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  // Outputs
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign delivered_o  = deliv_q;
  assign nautofd_o    = (state_q != ST_REQ);
  assign nstrobe_o    = 1'b1;
  assign nselectin_o  = 1'b1;
  assign ninit_o      = 1'b0;
  assign byte_valid_o = (state_q == ST_HOLD);
  assign byte_data_o  = data_q;
endmodule

// File: rtl/nibrx_chk.sv
module nibrx_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [CNT_W-1:0] delivered_o,
  input logic             nautofd_o,
  input logic             byte_valid_o,
  input logic [7:0]       byte_data_o,
  input logic             byte_ready_i
);
  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> nautofd_o);

  p_req_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nautofd_o |-> busy_o);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o));

  p_hold_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> nautofd_o && busy_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !err_o);

  p_err_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o);

  p_count_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !req_valid_i |=> $stable(delivered_o));
endmodule

bind nibrx_top nibrx_chk #(.CNT_W(CNT_W)) u_nibrx_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .delivered_o  (delivered_o),
  .nautofd_o    (nautofd_o),
  .byte_valid_o (byte_valid_o),
  .byte_data_o  (byte_data_o),
  .byte_ready_i (byte_ready_i)
);

// File: tb/test_nibrx_top.sv
`timescale 1ns/1ps
module test_nibrx_top;
  localparam int unsigned CNT_W = 9;
  localparam int unsigned FIRST = 40;
  localparam int unsigned STEP  = 6;
  localparam int unsigned DIV   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic             busy, done, err;
  logic [CNT_W-1:0] delivered;
  logic             nack = 1'b1;
  logic [3:0]       nib = 4'hF;
  logic             nautofd, nstrobe, nselectin, ninit;
  logic             bvalid;
  logic [7:0]       bdata;
  logic             rdy = 1'b1;

  nibrx_top #(.CNT_W(CNT_W), .TICK_DIV(DIV), .FIRST_LIMIT(FIRST),
              .STEP_LIMIT(STEP), .SYNC_STAGES(2)) i_nibrx_top (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_count_i(req_count),
    .busy_o(busy), .done_o(done), .err_o(err), .delivered_o(delivered),
    .nack_n_i(nack), .nfault_i(nib[0]), .select_i(nib[1]), .perror_i(nib[2]),
    .pbusy_i(nib[3]), .nautofd_o(nautofd), .nstrobe_o(nstrobe),
    .nselectin_o(nselectin), .ninit_o(ninit), .byte_valid_o(bvalid),
    .byte_data_o(bdata), .byte_ready_i(rdy)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int done_seen = 0;
  int rx_idx = 0;
  logic [7:0] exp_b [256];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (done) done_seen++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // Consumer: a byte accepted at the next edge is compared here
  always @(negedge clk) begin
    if (rst_n && bvalid && rdy) begin
      check(bdata[3:0] == exp_b[rx_idx][3:0], "R3 low nibble", bdata[3:0], exp_b[rx_idx][3:0]);
      check(bdata[7:4] == exp_b[rx_idx][7:4], "R4 high nibble", bdata[7:4], exp_b[rx_idx][7:4]);
      rx_idx++;
    end
  end

  task automatic wait_fd(input logic v, input int lim, input string tag);
    bit ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (nautofd == v) begin ok = 1'b1; break; end
    end
    check(ok, tag, nautofd, v);
  endtask

  task automatic send_nib(input logic [3:0] n, input int dly, input string tag);
    wait_fd(1'b0, 400, "R5 request");
    repeat (dly) @(negedge clk);
    nib = n;
    @(negedge clk);
    nack = 1'b0;
    wait_fd(1'b1, 10, tag);
    @(negedge clk);
    nack = 1'b1;
    nib = ~n;
  endtask

  task automatic send_byte(input logic [7:0] b, input int dly);
    send_nib(b[3:0], dly, "R3 nautofd rise");
    send_nib(b[7:4], 0, "R4 nautofd rise");
  endtask

  task automatic start(input int cnt);
    @(negedge clk);
    req_count = CNT_W'(cnt);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(nautofd == 1'b1, "R1 nautofd", nautofd, 1);
    check(nstrobe == 1'b1 && nselectin == 1'b1, "R1 strobe/selectin", {nstrobe, nselectin}, 3);
    check(ninit == 1'b0, "R1 ninit", ninit, 0);
    check({busy, bvalid, done, err} == 4'b0, "R1 flags", {busy, bvalid, done, err}, 0);

    // R10 zero count
    @(negedge clk);
    req_count = '0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R10 done", {done, busy}, 2);
    check(nautofd == 1'b1, "R10 no handshake", nautofd, 1);

    // Main sweep: all 256 byte values in one burst (R3, R4, R5, R7)
    for (int i = 0; i < 256; i++) exp_b[i] = 8'((i * 37 + 5) % 256);
    rx_idx = 0;
    d0 = done_seen;
    start(256);
    check(busy == 1'b1 && delivered == '0, "R2 started", busy, 1);
    for (int i = 0; i < 256; i++) begin
      send_byte(exp_b[i], 0);
      if (i == 0) begin
        req_count = CNT_W'(5);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    wait_idle(50);
    check(rx_idx == 256, "R7 bytes received", rx_idx, 256);
    check(delivered == CNT_W'(256), "R2 start ignored mid-burst / R7 count", delivered, 256);
    check(done_seen - d0 == 1, "R7 single done", done_seen - d0, 1);
    check(err == 1'b0, "R7 no error", err, 0);

    // R6 hold while consumer stalls
    rx_idx = 0;
    exp_b[0] = 8'hA5;
    exp_b[1] = 8'h3C;
    rdy = 1'b0;
    start(2);
    send_byte(8'hA5, 0);
    begin
      bit ok = 1'b1;
      repeat (6) @(negedge clk);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!(bvalid && bdata == 8'hA5 && nautofd)) ok = 1'b0;
      end
      check(ok, "R6 held with no request", bdata, 8'hA5);
    end
    rdy = 1'b1;
    send_byte(8'h3C, 0);
    wait_idle(50);
    check(rx_idx == 2 && delivered == CNT_W'(2), "R6 then R7 count", delivered, 2);

    // R8 slow but legal first nibble
    rx_idx = 0;
    exp_b[0] = 8'h96;
    start(1);
    send_byte(8'h96, 60);
    wait_idle(50);
    check(err == 1'b0 && delivered == CNT_W'(1), "R8 slow first nibble accepted", err, 0);

    // R8 first-nibble timeout keeps delivered count
    rx_idx = 0;
    exp_b[0] = 8'h11;
    start(3);
    send_byte(8'h11, 0);
    repeat (40) @(negedge clk);
    check(err == 1'b0 && busy == 1'b1, "R8 still waiting in long window", err, 0);
    repeat (80) @(negedge clk);
    check(err == 1'b1, "R8 timeout error", err, 1);
    check(busy == 1'b0 && nautofd == 1'b1, "R8 burst ended", busy, 0);
    check(delivered == CNT_W'(1), "R8 delivered kept", delivered, 1);

    // R9 second-nibble timeout uses the short limit
    start(1);
    check(err == 1'b0, "R2 error cleared on start", err, 1'b0);
    send_nib(4'h7, 0, "R3 nautofd rise");
    wait_fd(1'b0, 20, "R5 second request");
    repeat (30) @(negedge clk);
    check(err == 1'b1 && busy == 1'b0, "R9 step timeout", err, 1);
    check(delivered == '0, "R9 nothing delivered", delivered, 0);

    // Restart after error
    rx_idx = 0;
    exp_b[0] = 8'hE1;
    start(1);
    send_byte(8'hE1, 0);
    wait_idle(50);
    check(err == 1'b0 && delivered == CNT_W'(1) && rx_idx == 1, "R2 restart after error", delivered, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule